// File: doc/BRIEF.md
# Endianness-aware byte-lane steering unit

This block sits between a bus slave's internal word storage and a 32-bit or 64-bit system data bus. It receives the low address bits of a transfer, the transfer size as a power-of-two byte count, and a static byte-order mode. From these it works out which bus byte lanes are active and in what order the bytes of the data item occupy them.

On the write side it gathers the item from the active lanes of the incoming write bus. It returns the item right-justified and zero-extended, and it produces a one-bit-per-lane byte-enable mask for the storage. On the read side it takes a right-justified item from storage, places its bytes on the matching lanes of the read bus and drives every other lane to zero. Three byte orders are supported:
- little-endian;
- byte-invariant big-endian, where the lane choice is the same as little-endian but the most significant byte sits at the transfer address;
- word-invariant big-endian, where the lane order inside each 32-bit word is reversed and wider items are split into 32-bit words, with the less significant word at the lower address.

The steering logic is combinational. A parameter adds one output register stage, which is present by default.

Top module: `lane_steer`

## Requirements
- R1: With `endian_mode` 0 (or the spare code 3, treated the same), byte k of the item (k=0 least significant) uses lane (offset + k) mod bus bytes. A byte at offset 2 uses bits [23:16], and word 0x11223344 at offset 0 reads as 0x11223344 on the bus.
- R2: With `endian_mode` 1, lanes are chosen as in R1 but byte order is reversed: the most significant byte uses the lane of the transfer address. Word 0x11223344 at offset 0 appears as 0x44332211.
- R3: With `endian_mode` 2, a byte at offset o uses lane (o with its two low bits inverted). Offset 2 uses bits [15:8] and offset 6 uses bits [47:40].
- R4: With `endian_mode` 2, a 32-bit item occupies its word's lanes in the same bit positions as little-endian. A 64-bit item 0x1122334455667788 appears on the bus unchanged, so address bytes 0..7 hold 55 66 77 88 11 22 33 44.
- R5: With `endian_mode` 2, a 16-bit item at word byte offset b (0 or 2) occupies lanes word+2−b and word+3−b. The more significant byte is on the higher lane, so it sits at the lower address.
- R6: `xfer_size` s encodes 2^s bytes. For an aligned access, `lane_en` has exactly 2^s bits set, and those bits are exactly the lanes used by R1–R5.
- R7: Read lanes whose `lane_en` bit is clear are driven to zero, and bytes of `rword_in` above the item size have no effect on `rbus_out`.
- R8: `wword_out` carries the item gathered from the active write lanes, right-justified. Bytes above the item size are zero, and inactive write lanes have no effect.
- R9: When the offset is not a multiple of the item size, or 2^s exceeds the bus width, `misalign` is 1 and `lane_en`, `rbus_out` and `wword_out` are all zero.
- R10: With OUT_REG=1, outputs reflect the inputs one clock after they are applied, and they are all zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_addr | input | $clog2(BUS_W/8) | Transfer address modulo the bus width in bytes |
| xfer_size | input | 3 | Log2 of the item size in bytes |
| endian_mode | input | 2 | 0/3 little, 1 byte-invariant big, 2 word-invariant big |
| wbus_in | input | BUS_W | Write data bus from the master |
| rword_in | input | BUS_W | Right-justified item read from storage |
| wword_out | output | BUS_W | Right-justified item gathered from the write bus |
| rbus_out | output | BUS_W | Read data bus with the item steered onto its lanes |
| lane_en | output | BUS_W/8 | Active byte lanes, one bit per lane |
| misalign | output | 1 | Transfer rejected as misaligned or wider than the bus |

## Verification
The hardest situation to reach is a word-invariant halfword or byte in the upper word of a 64-bit bus. There, lane reversal inside the word combines with the word offset, and an error in either part still looks right in the lower word. The stimulus sweeps every aligned offset for every size in every mode, and it fills all inactive write lanes and all unused storage bytes with random bytes, so that any lane leakage becomes visible. Misaligned and oversized requests are placed between valid ones to show that rejection leaves no stale data on the outputs.

// File: rtl/steer_pkg.sv
`timescale 1ns/1ps
package steer_pkg;
    typedef enum logic [1:0] {
        END_LITTLE   = 2'd0,
        END_BIG_BYTE = 2'd1,
        END_BIG_WORD = 2'd2,
        END_SPARE    = 2'd3
    } endian_e;
endpackage

// File: rtl/steer_lane_map.sv
`timescale 1ns/1ps
module steer_lane_map
    import steer_pkg::*;
#(
    parameter  int NB   = 8,
    localparam int OFFW = $clog2(NB)
) (
    input  logic [OFFW-1:0]           off,
    input  logic [2:0]                size,
    input  logic [1:0]                mode,
    output logic [NB-1:0][OFFW-1:0]   lane_of,
    output logic [NB-1:0][OFFW-1:0]   src_of,
    output logic [NB-1:0]             act,
    output logic                      bad
);
    // item byte k travels on lane lane_of[k] and holds item byte src_of[k]
    always_comb begin
        int  nbytes;
        int  chunk;
        int  a;
        logic oversize;
        lane_of  = '0;
        src_of   = '0;
        act      = '0;
        oversize = int'(size) > OFFW;
        nbytes   = oversize ? 0 : (1 << size);
        chunk    = (nbytes > 4) ? 4 : nbytes;
        bad      = oversize || ((int'(off) & (nbytes - 1)) != 0);
        for (int k = 0; k < NB; k++) begin
            a      = (int'(off) + k) % NB;
            act[k] = !bad && (k < nbytes);
            case (endian_e'(mode))
                END_BIG_WORD: begin
                    lane_of[k] = OFFW'(a ^ 3);
                    src_of[k]  = OFFW'((k & ~3) + chunk - 1 - (k & 3));
                end
                END_BIG_BYTE: begin
                    lane_of[k] = OFFW'(a);
                    src_of[k]  = OFFW'(nbytes - 1 - k);
                end
                default: begin
                    lane_of[k] = OFFW'(a);
                    src_of[k]  = OFFW'(k);
                end
            endcase
        end
    end
endmodule

// File: rtl/steer_wr_gather.sv
`timescale 1ns/1ps
module steer_wr_gather #(
    parameter  int NB   = 8,
    localparam int OFFW = $clog2(NB)
) (
    input  logic [NB*8-1:0]         bus,
    input  logic [NB-1:0][OFFW-1:0] lane_of,
    input  logic [NB-1:0][OFFW-1:0] src_of,
    input  logic [NB-1:0]           act,
    output logic [NB*8-1:0]         item
);
    always_comb begin
        item = '0;
        for (int k = 0; k < NB; k++) begin
            if (act[k]) item[src_of[k]*8 +: 8] = bus[lane_of[k]*8 +: 8];
        end
    end
endmodule

// File: rtl/steer_rd_scatter.sv
`timescale 1ns/1ps
module steer_rd_scatter #(
    parameter  int NB   = 8,
    localparam int OFFW = $clog2(NB)
) (
    input  logic [NB*8-1:0]         item,
    input  logic [NB-1:0][OFFW-1:0] lane_of,
    input  logic [NB-1:0][OFFW-1:0] src_of,
    input  logic [NB-1:0]           act,
    output logic [NB*8-1:0]         bus,
    output logic [NB-1:0]           en
);
    always_comb begin
        bus = '0;
        en  = '0;
        for (int k = 0; k < NB; k++) begin
            if (act[k]) begin
                bus[lane_of[k]*8 +: 8] = item[src_of[k]*8 +: 8];
                en[lane_of[k]]         = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lane_steer.sv
`timescale 1ns/1ps
module lane_steer #(
    parameter int BUS_W   = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(BUS_W/8)-1:0]   lane_addr,
    input  logic [2:0]                   xfer_size,
    input  logic [1:0]                   endian_mode,
    input  logic [BUS_W-1:0]             wbus_in,
    input  logic [BUS_W-1:0]             rword_in,
    output logic [BUS_W-1:0]             wword_out,
    output logic [BUS_W-1:0]             rbus_out,
    output logic [BUS_W/8-1:0]           lane_en,
    output logic                         misalign
);
    localparam int NB   = BUS_W / 8;
    localparam int OFFW = $clog2(NB);

    typedef struct packed {
        logic [BUS_W-1:0] wword;
        logic [BUS_W-1:0] rbus;
        logic [NB-1:0]    en;
        logic             mis;
    } steer_out_t;

    logic [NB-1:0][OFFW-1:0] lane_of;
    logic [NB-1:0][OFFW-1:0] src_of;
    logic [NB-1:0]           act;
    logic                    bad;
    logic [BUS_W-1:0]        gathered;
    logic [BUS_W-1:0]        scattered;
    logic [NB-1:0]           en_raw;
    steer_out_t              out_d;
    steer_out_t              out_q;

    steer_lane_map #(.NB(NB)) u_map (
        .off     (lane_addr),
        .size    (xfer_size),
        .mode    (endian_mode),
        .lane_of (lane_of),
        .src_of  (src_of),
        .act     (act),
        .bad     (bad)
    );

    steer_wr_gather #(.NB(NB)) u_gather (
        .bus     (wbus_in),
        .lane_of (lane_of),
        .src_of  (src_of),
        .act     (act),
        .item    (gathered)
    );

    steer_rd_scatter #(.NB(NB)) u_scatter (
        .item    (rword_in),
        .lane_of (lane_of),
        .src_of  (src_of),
        .act     (act),
        .bus     (scattered),
        .en      (en_raw)
    );

    always_comb begin
        out_d.wword = gathered;
        out_d.rbus  = scattered;
        out_d.en    = en_raw;
        out_d.mis   = bad;
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
    end else begin : g_comb
        assign out_q = out_d;
    end

    assign wword_out = out_q.wword;
    assign rbus_out  = out_q.rbus;
    assign lane_en   = out_q.en;
    assign misalign  = out_q.mis;
endmodule

// File: rtl/lane_steer_chk.sv
`timescale 1ns/1ps
module lane_steer_chk #(
    parameter  int BUS_W   = 64,
    parameter  bit OUT_REG = 1'b1,
    localparam int NB      = BUS_W / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       xfer_size,
    input logic [BUS_W-1:0] wword_out,
    input logic [BUS_W-1:0] rbus_out,
    input logic [NB-1:0]    lane_en,
    input logic             misalign
);
    logic       armed;
    logic [2:0] sz_ref;

    function automatic logic [BUS_W-1:0] lanes_to_bits(input logic [NB-1:0] en);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int i = 0; i < NB; i++) if (en[i]) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                armed  <= 1'b0;
                sz_ref <= 3'd0;
            end else begin
                armed  <= 1'b1;
                sz_ref <= xfer_size;
            end
        end
        // R10
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (lane_en == '0 && rbus_out == '0 && wword_out == '0 && !misalign));
    end else begin : g_comb
        assign armed  = 1'b1;
        assign sz_ref = xfer_size;
    end

    // R9
    reject_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (lane_en == '0 && rbus_out == '0 && wword_out == '0));

    // R6
    en_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !misalign) |-> ($countones(lane_en) == (1 << sz_ref)));

    // R7
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rbus_out & ~lanes_to_bits(lane_en)) == '0);

    // R8
    wword_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !misalign) |-> ((wword_out >> (8 << sz_ref)) == '0));
endmodule

bind lane_steer lane_steer_chk #(.BUS_W(BUS_W), .OUT_REG(OUT_REG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_size (xfer_size),
    .wword_out (wword_out),
    .rbus_out  (rbus_out),
    .lane_en   (lane_en),
    .misalign  (misalign)
);

// File: tb/lane_steer_tb.sv
`timescale 1ns/1ps
module lane_steer_tb;
    localparam int BUS_W = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  lane_addr;
    logic [2:0]  xfer_size;
    logic [1:0]  endian_mode;
    logic [63:0] wbus_in;
    logic [63:0] rword_in;
    logic [63:0] wword_out;
    logic [63:0] rbus_out;
    logic [7:0]  lane_en;
    logic        misalign;

    always #10 clk = ~clk;

    lane_steer #(.BUS_W(BUS_W), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .lane_addr(lane_addr), .xfer_size(xfer_size),
        .endian_mode(endian_mode), .wbus_in(wbus_in), .rword_in(rword_in),
        .wword_out(wword_out), .rbus_out(rbus_out), .lane_en(lane_en), .misalign(misalign)
    );

    typedef struct {
        string       tag;
        logic [63:0] ww;
        logic [63:0] rb;
        logic [7:0]  en;
        logic        mis;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;

    function automatic logic [63:0] bytes_mask(int n);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    function automatic logic [63:0] rev_bytes(logic [63:0] v, int n);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < n; i++) r[i*8 +: 8] = v[(n-1-i)*8 +: 8];
        return r;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // driver: applies one transfer and pushes the expected result
    task automatic xfer(string tag, int mode, int off, int sz, logic [63:0] v);
        int          n;
        int          sh;
        bit          bad;
        logic [63:0] item;
        logic [63:0] bus;
        logic [63:0] garb;
        exp_t        e;
        garb = {$urandom, $urandom};
        if (sz > 3) begin
            n = 0;
            bad = 1'b1;
        end else begin
            n = 1 << sz;
            bad = (off % n) != 0;
        end
        item = v & bytes_mask(n);
        if (mode == 2) sh = (off & ~3) + ((n >= 4) ? 0 : (4 - (off & 3) - n));
        else           sh = off;
        bus = ((mode == 1) ? rev_bytes(item, n) : item) << (8 * sh);
        @(negedge clk);
        lane_addr   = 3'(off);
        xfer_size   = 3'(sz);
        endian_mode = 2'(mode);
        rword_in    = item | (garb & ~bytes_mask(n));
        wbus_in     = bad ? garb : (bus | (garb & ~(bytes_mask(n) << (8 * sh))));
        e.tag = tag;
        if (bad) begin
            e.ww = '0; e.rb = '0; e.en = '0; e.mis = 1'b1;
        end else begin
            e.ww = item; e.rb = bus; e.en = 8'(((1 << n) - 1) << sh); e.mis = 1'b0;
        end
        sb.push_back(e);
    endtask

    // monitor: one registered result per clock after each applied transfer
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "R6 lane_en",  64'(lane_en),  64'(e.en));
            chk(e.tag, "R7 rbus_out", rbus_out,      e.rb);
            chk(e.tag, "R8 wword_out", wword_out,    e.ww);
            chk(e.tag, "R9 misalign", 64'(misalign), 64'(e.mis));
        end
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL R10 watchdog expired: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        lane_addr = '0; xfer_size = '0; endian_mode = '0;
        wbus_in = 64'hDEAD_BEEF_CAFE_F00D; rword_in = 64'h0123_4567_89AB_CDEF;
        repeat (3) @(negedge clk);
        chk("R10 reset", "lane_en",   64'(lane_en),  64'h0);
        chk("R10 reset", "rbus_out",  rbus_out,      64'h0);
        chk("R10 reset", "wword_out", wword_out,     64'h0);
        chk("R10 reset", "misalign",  64'(misalign), 64'h0);
        rst_n = 1'b1;

        xfer("R1 little byte off2",        0, 2, 0, 64'hA5);
        xfer("R1 little word off0",        0, 0, 2, 64'h11223344);
        xfer("R1 spare code word off4",    3, 4, 2, 64'h99AABBCC);
        xfer("R2 byte-inv big word off0",  1, 0, 2, 64'h11223344);
        xfer("R2 byte-inv big half off6",  1, 6, 1, 64'h1234);
        xfer("R3 word-inv big byte off2",  2, 2, 0, 64'h5A);
        xfer("R3 word-inv big byte off6",  2, 6, 0, 64'hC3);
        xfer("R4 word-inv big word off4",  2, 4, 2, 64'h11223344);
        xfer("R4 word-inv big dword",      2, 0, 3, 64'h1122334455667788);
        xfer("R5 word-inv big half off0",  2, 0, 1, 64'hBEEF);
        xfer("R5 word-inv big half off2",  2, 2, 1, 64'hF00D);
        xfer("R5 word-inv big half off6",  2, 6, 1, 64'h7E81);
        xfer("R9 half at odd offset",      0, 1, 1, 64'h1111);
        xfer("R9 word at offset 2",        2, 2, 2, 64'h22222222);
        xfer("R9 dword at offset 4",       1, 4, 3, 64'h3333333333333333);
        xfer("R9 size wider than bus",     0, 0, 4, 64'h4444);
        xfer("R7 after reject",            0, 3, 0, 64'h77);

        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int o = 0; o < 8; o += (1 << s)) begin
                    xfer("R6 sweep", m, o, s, {$urandom, $urandom});
                end
            end
        end

        wait (sb.size() == 0);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule